// File: doc/BRIEF.md
# GNSS Spread-Spectrum Tracking Channel

This block is one correlation channel of a satellite-navigation receiver. It divides the master clock down to a sample strobe, which it also drives out to the RF front end. On each strobe it takes one 2-bit sign/magnitude sample. A carrier phase accumulator removes the residual carrier with coarse three-level sine and cosine values, which gives an in-phase and a quadrature term. Both terms are multiplied by a locally generated Gold-code replica, and the products are summed over one full 1023-chip code period.

A code phase accumulator sets the chip rate. Its carry steps the replica by one chip, so software can run the code at the nominal 1.023 Mchip/s or at any rate near it. Software programs the carrier increment, the code increment, the two code taps that select the satellite, and an enable bit, all through a small word-wide register port. At every code epoch the two sums are copied into readout registers and a done flag is raised. Reading either result clears that flag.

When the channel is disabled, all of its state is frozen so that it stops switching. The sample strobe keeps running.

Top module: `gnssTrackChan`

## Requirements
- R1: After reset every register (addresses 0 to 6) reads zero, accDone is low and the channel is disabled.
- R2: sampleClk repeats every 7 master cycles, high for 4 cycles and then low for 3, and it is high in the first cycle after reset. The channel consumes one sample per period.
- R3: An input sample is worth +1 when sign=0 and mag=0, +3 when sign=0 and mag=1, -1 when sign=1 and mag=0, and -3 when sign=1 and mag=1.
- R4: A 32-bit carrier phase starts at zero and adds the increment at address 0 after each sample. Its top 3 bits form a sector s. For s = 0..7 the cosine level is +1,0,0,-1,-1,0,0,+1 and the sine level is 0,+1,+1,0,0,-1,-1,0. The in-phase term is the sample times the cosine level, and the quadrature term is the sample times the sine level.
- R5: The replica comes from two 10-stage shift registers, both all ones at start. G1 feeds back stages 3 and 10, and G2 feeds back stages 2, 3, 6, 8, 9 and 10. The chip value is G1 stage 10 XOR G2 stage A XOR G2 stage B. A is address 2 bits [3:0] and B is address 2 bits [11:8], each in the range 1 to 10. A chip of 1 negates the product. Writing address 2 restarts the channel: both phases, the chip index and the sums go to zero, and accDone clears.
- R6: A 32-bit code phase adds the increment at address 1 after each sample. Each carry advances one chip, and the chip index runs 0..1022 and then wraps to 0. With an increment of 0x80000000 a code period lasts 2046 samples, which is 14322 master cycles.
- R7: Address 3 bit 0 enables the channel. While it is 0, the phases, the code state and the sums are held and no epoch occurs. Re-enabling resumes the channel exactly where it stopped.
- R8: On the sample at which the chip index wraps from 1022 to 0, the I and Q sums, including that sample, are stored at addresses 4 and 5 as signed 16-bit values sign-extended to 32 bits. The running sums then restart from zero, and accDone (also address 6 bit 0) is set.
- R9: A read strobe at address 4 or 5 clears accDone on the next cycle, unless an epoch occurs in the same cycle, in which case the epoch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sign | input | 1 | Sample polarity bit (1 = negative) |
| mag | input | 1 | Sample amplitude bit (1 = large) |
| sampleClk | output | 1 | Sample clock to the front end, 4 high / 3 low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Read strobe, clears accDone at address 4 or 5 |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Read data for rdAddr, combinational |
| accDone | output | 1 | Epoch results ready |

## Verification
The checks assume that the code taps lie between 1 and 10 and that a restart through address 2 is written only after both increments, so that the first period after it covers exactly one full code. The stimulus always sets the increments and the enable before writing the tap register. It holds sign and mag constant through each code period and uses a code increment of one half, so every epoch lands at a known sample. The checks also assume that reads clear the flag only through rdEn; the bench raises rdEn just for the result addresses, and only while no epoch is pending.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_CAR  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CODE = 3'd1;
  localparam logic [ADDR_W-1:0] REG_SEL  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CTL  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_RI   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_RQ   = 3'd5;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleTick;
    logic restart;
    logic runEn;
  } trkStrobes_t;
endpackage

// File: rtl/trkGoldGen.sv
module trkGoldGen #(
  parameter int LFSR_W = 10,
  parameter int CODE_LEN = 1023,
  parameter logic [LFSR_W-1:0] G1_MASK = 10'h204,
  parameter logic [LFSR_W-1:0] G2_MASK = 10'h3A6,
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             advance,
  input  logic [3:0]       tapA,
  input  logic [3:0]       tapB,
  output logic             chip,
  output logic [IDX_W-1:0] chipIdx,
  output logic             lastChip
);
  logic [LFSR_W-1:0] g1, g2;
  logic selA, selB;

  function automatic logic stageBit(input logic [LFSR_W-1:0] g, input logic [3:0] tap);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LFSR_W; i++) begin
      if (int'(tap) == i + 1) r = g[i];
    end
    return r;
  endfunction

  always_comb begin
    selA = stageBit(g2, tapA);
    selB = stageBit(g2, tapB);
  end

  assign chip     = g1[LFSR_W-1] ^ selA ^ selB;
  assign lastChip = (chipIdx == IDX_W'(CODE_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      g1 <= '1;
      g2 <= '1;
      chipIdx <= '0;
    end else if (restart) begin
      g1 <= '1;
      g2 <= '1;
      chipIdx <= '0;
    end else if (advance) begin
      g1 <= {g1[LFSR_W-2:0], ^(g1 & G1_MASK)};
      g2 <= {g2[LFSR_W-2:0], ^(g2 & G2_MASK)};
      chipIdx <= lastChip ? '0 : chipIdx + 1'b1;
    end
  end
endmodule

// File: rtl/trkDatapath.sv
module trkDatapath import trk_pkg::*; #(
  parameter int PHASE_W = 32,
  parameter int ACC_W = 16,
  parameter int LFSR_W = 10,
  parameter int CODE_LEN = 1023,
  localparam int IDX_W = $clog2(CODE_LEN),
  localparam int PROD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  trkStrobes_t        stb,
  input  logic [PHASE_W-1:0] carInc,
  input  logic [PHASE_W-1:0] codeInc,
  input  logic [3:0]         tapA,
  input  logic [3:0]         tapB,
  input  logic               sign,
  input  logic               mag,
  output logic [ACC_W-1:0]   sumI,
  output logic [ACC_W-1:0]   sumQ,
  output logic               epochStb,
  output logic [IDX_W-1:0]   chipIdx
);
  logic [PHASE_W-1:0] carPh, codePh, nextCode;
  logic codeCarry, step, chip, lastChip;
  logic [2:0] sector;
  logic [1:0] cosT, sinT;
  logic signed [PROD_W-1:0] smpVal, mixI, mixQ, corrI, corrQ;
  logic [ACC_W-1:0] accI, accQ;

  // tri-level code: 01 = +1, 11 = -1, 00 = 0
  function automatic logic signed [PROD_W-1:0] applyTri(
      input logic signed [PROD_W-1:0] v, input logic [1:0] t);
    case (t)
      2'b01:   return v;
      2'b11:   return -v;
      default: return '0;
    endcase
  endfunction

  assign step = stb.sampleTick && stb.runEn && !stb.restart;
  assign {codeCarry, nextCode} = {1'b0, codePh} + {1'b0, codeInc};
  assign sector = carPh[PHASE_W-1 -: 3];

  always_comb begin
    case (sector)
      3'd0, 3'd7: cosT = 2'b01;
      3'd3, 3'd4: cosT = 2'b11;
      default:    cosT = 2'b00;
    endcase
    case (sector)
      3'd1, 3'd2: sinT = 2'b01;
      3'd5, 3'd6: sinT = 2'b11;
      default:    sinT = 2'b00;
    endcase
  end

  always_comb begin
    smpVal = sign ? (mag ? -4'sd3 : -4'sd1) : (mag ? 4'sd3 : 4'sd1);
    mixI = applyTri(smpVal, cosT);
    mixQ = applyTri(smpVal, sinT);
    corrI = chip ? -mixI : mixI;
    corrQ = chip ? -mixQ : mixQ;
  end

  assign sumI = accI + {{(ACC_W-PROD_W){corrI[PROD_W-1]}}, corrI};
  assign sumQ = accQ + {{(ACC_W-PROD_W){corrQ[PROD_W-1]}}, corrQ};
  assign epochStb = step && codeCarry && lastChip;

  trkGoldGen #(.LFSR_W(LFSR_W), .CODE_LEN(CODE_LEN)) u_gold (
    .clk(clk), .rstN(rstN), .restart(stb.restart), .advance(step && codeCarry),
    .tapA(tapA), .tapB(tapB), .chip(chip), .chipIdx(chipIdx), .lastChip(lastChip)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carPh <= '0;
      codePh <= '0;
      accI <= '0;
      accQ <= '0;
    end else if (stb.restart) begin
      carPh <= '0;
      codePh <= '0;
      accI <= '0;
      accQ <= '0;
    end else if (step) begin
      carPh <= carPh + carInc;
      codePh <= nextCode;
      accI <= epochStb ? '0 : sumI;
      accQ <= epochStb ? '0 : sumQ;
    end
  end
endmodule

// File: rtl/trkCtrl.sv
module trkCtrl import trk_pkg::*; #(
  parameter int BUS_W = 32,
  parameter int ACC_W = 16,
  parameter int SMP_DIV = 7,
  parameter int SMP_HIGH = 4,
  localparam int CNT_W = $clog2(SMP_DIV)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic              sampleClk,
  output trkStrobes_t       stb,
  output logic [BUS_W-1:0]  carInc,
  output logic [BUS_W-1:0]  codeInc,
  output logic [3:0]        tapA,
  output logic [3:0]        tapB,
  output logic              chanEn,
  input  logic              epochStb,
  input  logic [ACC_W-1:0]  sumI,
  input  logic [ACC_W-1:0]  sumQ,
  output logic              accDone
);
  logic [CNT_W-1:0] smpCnt;
  logic [BUS_W-1:0] selReg, ctlReg;
  logic [ACC_W-1:0] resI, resQ;
  logic selWr, rdClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) smpCnt <= '0;
    else if (smpCnt == CNT_W'(SMP_DIV - 1)) smpCnt <= '0;
    else smpCnt <= smpCnt + 1'b1;
  end

  assign sampleClk = (smpCnt < CNT_W'(SMP_HIGH));
  assign selWr = wrEn && (wrAddr == REG_SEL);
  assign rdClr = rdEn && ((rdAddr == REG_RI) || (rdAddr == REG_RQ));
  assign chanEn = ctlReg[0];
  assign tapA = selReg[3:0];
  assign tapB = selReg[11:8];

  always_comb begin
    stb.sampleTick = (smpCnt == CNT_W'(SMP_DIV - 1));
    stb.restart = selWr;
    stb.runEn = chanEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carInc <= '0;
      codeInc <= '0;
      selReg <= '0;
      ctlReg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_CAR:  carInc <= wrData;
        REG_CODE: codeInc <= wrData;
        REG_SEL:  selReg <= wrData;
        REG_CTL:  ctlReg <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resI <= '0;
      resQ <= '0;
    end else if (epochStb) begin
      resI <= sumI;
      resQ <= sumQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accDone <= 1'b0;
    else if (selWr) accDone <= 1'b0;
    else if (epochStb) accDone <= 1'b1;
    else if (rdClr) accDone <= 1'b0;
  end

  always_comb begin
    case (rdAddr)
      REG_CAR:  rdData = carInc;
      REG_CODE: rdData = codeInc;
      REG_SEL:  rdData = selReg;
      REG_CTL:  rdData = ctlReg;
      REG_RI:   rdData = {{(BUS_W-ACC_W){resI[ACC_W-1]}}, resI};
      REG_RQ:   rdData = {{(BUS_W-ACC_W){resQ[ACC_W-1]}}, resQ};
      REG_STAT: rdData = {{(BUS_W-1){1'b0}}, accDone};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gnssTrackChan.sv
module gnssTrackChan import trk_pkg::*; #(
  parameter int BUS_W = 32,
  parameter int ACC_W = 16,
  parameter int SMP_DIV = 7,
  parameter int SMP_HIGH = 4,
  parameter int LFSR_W = 10,
  parameter int CODE_LEN = 1023,
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sign,
  input  logic              mag,
  output logic              sampleClk,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [2:0]        rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic              accDone
);
  trkStrobes_t stb;
  logic [BUS_W-1:0] carInc, codeInc;
  logic [3:0] tapA, tapB;
  logic chanEn, epochStb;
  logic [ACC_W-1:0] sumI, sumQ;
  logic [IDX_W-1:0] chipIdx;

  trkCtrl #(.BUS_W(BUS_W), .ACC_W(ACC_W), .SMP_DIV(SMP_DIV), .SMP_HIGH(SMP_HIGH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .sampleClk(sampleClk),
    .stb(stb), .carInc(carInc), .codeInc(codeInc), .tapA(tapA), .tapB(tapB),
    .chanEn(chanEn), .epochStb(epochStb), .sumI(sumI), .sumQ(sumQ), .accDone(accDone)
  );

  trkDatapath #(.PHASE_W(BUS_W), .ACC_W(ACC_W), .LFSR_W(LFSR_W), .CODE_LEN(CODE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .carInc(carInc), .codeInc(codeInc),
    .tapA(tapA), .tapB(tapB), .sign(sign), .mag(mag), .sumI(sumI), .sumQ(sumQ),
    .epochStb(epochStb), .chipIdx(chipIdx)
  );
endmodule

// File: rtl/trkChecker.sv
module trkChecker #(
  parameter int SMP_DIV = 7,
  parameter int SMP_HIGH = 4,
  parameter int CODE_LEN = 1023,
  localparam int IDX_W = $clog2(CODE_LEN)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleClk,
  input logic             accDone,
  input logic             chanEn,
  input logic [IDX_W-1:0] chipIdx,
  input logic             epochStb,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic             rdEn,
  input logic [2:0]       rdAddr
);
  logic [3:0] hiRun, loRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= '0;
      loRun <= '0;
    end else begin
      hiRun <= sampleClk ? hiRun + 1'b1 : '0;
      loRun <= sampleClk ? '0 : loRun + 1'b1;
    end
  end

  a_r2_high_run: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleClk) |-> hiRun == 4'(SMP_HIGH));
  a_r2_low_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleClk) |-> loRun == 4'(SMP_DIV - SMP_HIGH));
  a_r6_chip_range: assert property (@(posedge clk) disable iff (!rstN)
    chipIdx < IDX_W'(CODE_LEN));
  a_r6_epoch_wrap: assert property (@(posedge clk) disable iff (!rstN)
    epochStb |=> chipIdx == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && !(wrEn && wrAddr == 3'd2)) |=> $stable(chipIdx));
  a_r7_no_epoch: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> !epochStb);
  a_r8_done_set: assert property (@(posedge clk) disable iff (!rstN)
    epochStb |=> accDone);
  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (rdAddr == 3'd4 || rdAddr == 3'd5) && !epochStb) |=> !accDone);
endmodule

bind gnssTrackChan trkChecker #(.SMP_DIV(SMP_DIV), .SMP_HIGH(SMP_HIGH), .CODE_LEN(CODE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .sampleClk(sampleClk), .accDone(accDone), .chanEn(chanEn),
  .chipIdx(chipIdx), .epochStb(epochStb), .wrEn(wrEn), .wrAddr(wrAddr),
  .rdEn(rdEn), .rdAddr(rdAddr)
);

// File: tb/sim_gnssTrackChan.sv
`timescale 1ns/1ps
module sim_gnssTrackChan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sign = 1'b0, mag = 1'b0;
  logic sampleClk, accDone;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int nChecks = 0, nErr = 0;
  longint cyc = 0;

  typedef struct packed {
    logic sgn;
    logic mg;
    logic [31:0] car;
    logic [3:0] ta;
    logic [3:0] tb;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b1, 32'h0000_0000, 4'd2, 4'd6},
    '{1'b1, 1'b0, 32'h0000_0000, 4'd3, 4'd7},
    '{1'b0, 1'b1, 32'h4000_0000, 4'd2, 4'd6},
    '{1'b1, 1'b1, 32'h4000_0000, 4'd5, 4'd9}
  };
  localparam logic [31:0] CODE_HALF = 32'h8000_0000;

  gnssTrackChan u0 (
    .clk(clk), .rstN(rstN), .sign(sign), .mag(mag), .sampleClk(sampleClk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .accDone(accDone)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // signed code sum from the two-register generator (R5); alt negates odd chips
  function automatic int goldSum(input int ta, input int tb, input bit alt);
    logic [9:0] g1, g2;
    int s;
    bit c;
    int v;
    g1 = '1; g2 = '1; s = 0;
    for (int j = 0; j < 1023; j++) begin
      c = g1[9] ^ g2[ta-1] ^ g2[tb-1];
      v = c ? -1 : 1;
      if (alt && j[0]) v = -v;
      s += v;
      g1 = {g1[8:0], g1[2] ^ g1[9]};
      g2 = {g2[8:0], g2[1] ^ g2[2] ^ g2[5] ^ g2[7] ^ g2[8] ^ g2[9]};
    end
    return s;
  endfunction

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, input bit clr, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
    rdEn = clr;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitDone(input int lim, output bit seen, output longint at);
    seen = 1'b0; at = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (accDone) begin
        seen = 1'b1; at = cyc; return;
      end
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    bit seen;
    longint t1, t2;
    vec_t v;
    int mult, s, expI, expQ, s0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R2: sample clock pattern from the first cycle after reset
    for (int i = 0; i < 14; i++) begin
      #1;
      chk("R2", "sampleClk", sampleClk, (i % 7) < 4);
      @(negedge clk);
    end
    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rdReg(3'(a), 1'b0, d);
      chk("R1", $sformatf("reg%0d", a), d, 0);
    end
    chk("R1", "accDone", accDone, 0);

    // vector table
    for (int k = 0; k < 4; k++) begin
      v = VECS[k];
      sign = v.sgn; mag = v.mg;
      mult = v.sgn ? (v.mg ? -3 : -1) : (v.mg ? 3 : 1);
      if (v.car == 0) begin
        s = goldSum(int'(v.ta), int'(v.tb), 1'b0);
        expI = 2 * mult * s; expQ = 0;
      end else begin
        s = goldSum(int'(v.ta), int'(v.tb), 1'b1);
        expI = mult * s; expQ = mult * s;
      end
      wrReg(3'd0, v.car);
      wrReg(3'd1, CODE_HALF);
      wrReg(3'd3, 32'd1);
      wrReg(3'd2, {20'b0, v.tb, 4'b0, v.ta});
      rdReg(3'd0, 1'b0, d);
      chk("R4", "carrier inc readback", d, v.car);
      rdReg(3'd2, 1'b0, d);
      chk("R5", "tap readback", d, {20'b0, v.tb, 4'b0, v.ta});
      waitDone(16000, seen, t1);
      chk("R8", $sformatf("vec%0d done", k), seen, 1);
      rdReg(3'd6, 1'b0, d);
      chk("R8", "status bit", d, 1);
      rdReg(3'd4, 1'b1, d);
      chk("R3", $sformatf("vec%0d I", k), longint'($signed(d)), expI);
      rdReg(3'd5, 1'b1, d);
      chk("R4", $sformatf("vec%0d Q", k), longint'($signed(d)), expQ);
      #1;
      chk("R9", "done cleared by read", accDone, 0);
    end

    // R6: epoch period and steady-state result
    s0 = goldSum(2, 6, 1'b0);
    sign = 1'b0; mag = 1'b1;
    wrReg(3'd0, 32'd0);
    wrReg(3'd1, CODE_HALF);
    wrReg(3'd3, 32'd1);
    wrReg(3'd2, {20'b0, 4'd6, 4'b0, 4'd2});
    waitDone(16000, seen, t1);
    rdReg(3'd4, 1'b1, d);
    waitDone(16000, seen, t2);
    chk("R6", "epoch period cycles", t2 - t1, 14322);
    rdReg(3'd4, 1'b1, d);
    chk("R8", "second epoch I", longint'($signed(d)), 6 * s0);

    // R7: disable holds state
    wrReg(3'd2, {20'b0, 4'd6, 4'b0, 4'd2});
    repeat (7000) @(negedge clk);
    wrReg(3'd3, 32'd0);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (accDone) seen = 1'b1;
    end
    chk("R7", "no epoch while disabled", seen, 0);
    rdReg(3'd3, 1'b0, d);
    chk("R7", "enable readback", d, 0);
    wrReg(3'd3, 32'd1);
    waitDone(16000, seen, t1);
    chk("R7", "done after resume", seen, 1);
    rdReg(3'd4, 1'b1, d);
    chk("R7", "I after pause", longint'($signed(d)), 6 * s0);

    finishRun();
  end
endmodule